// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns characters written by a host into asynchronous serial frames on a single line. A one-character holding buffer sits in front of a frame shifter. The host can therefore queue the next character while the current one is still going out, and consecutive frames leave with no idle gap between them. Each frame carries 5 to 9 data bits, an optional parity bit and one or two stop bits. The parity bit is computed automatically.

Bit timing comes from an external bit-rate tick, which is a single-cycle pulse once per bit period. The block reports two flags. One says the holding buffer can take a new character. The other says the line has gone quiet with nothing queued. Each flag has its own interrupt request, gated by an enable bit and by a global enable.

A transmitter enable controls whether the line is driven. Turning the enable off does not cut a frame short: the block first sends everything it already holds, and only then stops driving the line. While the line is not driven, the output reads high.

Top module: `uart_tx_buffered`

## Requirements
- R1: After reset, `buf_empty` is 1, `tx_done` is 0, `tx` is 1 and `tx_drive` is 0.
- R2: A pulse on `wr_data` stores `{ninth_bit register, wdata}` in the buffer and clears `buf_empty` on the next cycle, but only when `tx_en` is 1 and `buf_empty` is 1. Otherwise the write is ignored and `buf_empty` stays 1.
- R3: A frame is a start bit 0, then the data bits LSB first, then an optional parity bit, then the stop bits of 1. The line idles at 1. The data-bit count is 5+`char_len` for `char_len` values 0 to 4, and 9 for values 5 to 7. Each frame bit appears on `tx` in the cycle after a `bit_tick` and is held until the cycle after the next one.
- R4: When `par_en` is 1, a parity bit follows the data bits. With `par_odd` at 0 it equals the XOR of the data bits (even parity). With `par_odd` at 1 it is the inverse of that XOR (odd parity).
- R5: `two_stop` at 1 sends two stop bits. At 0 it sends one.
- R6: A pulse on `wr_ninth` loads `ninth_in` into the ninth-bit register. A later data write copies that register into data bit 8, which is sent when the frame has 9 data bits.
- R7: On a `bit_tick` where the shifter is idle, or is ending the last stop bit, a full buffer moves into the shifter. The start bit goes out at once and `buf_empty` returns to 1. Back-to-back frames therefore have no idle bit between them.
- R8: `tx_done` is set by the tick that ends the last stop bit, provided the buffer is empty and no data write is accepted in that cycle. A setting event wins over a clear in the same cycle.
- R9: `tx_done` is cleared by a pulse on `done_clr` (write one) or on `done_ack` (interrupt serviced).
- R10: `empty_irq` = `empty_ie` AND `gie` AND `buf_empty`, and `done_irq` = `done_ie` AND `gie` AND `tx_done`.
- R11: `tx_drive` goes to 1 in the cycle after `tx_en` is seen high. After `tx_en` falls, `tx_drive` stays 1 until both the buffer and the shifter are empty, and then drops to 0. While `tx_drive` is 0, `tx` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable |
| char_len | input | 3 | Data-bit count select (0..4 gives 5..9 bits, 5..7 gives 9) |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| wr_data | input | 1 | Data write strobe |
| wdata | input | 8 | Low eight data bits |
| wr_ninth | input | 1 | Ninth-bit register write strobe |
| ninth_in | input | 1 | Ninth-bit value |
| done_clr | input | 1 | Write-one clear of tx_done |
| done_ack | input | 1 | Interrupt acknowledge for tx_done |
| gie | input | 1 | Global interrupt enable |
| empty_ie | input | 1 | Buffer-empty interrupt enable |
| done_ie | input | 1 | Transmit-complete interrupt enable |
| tx | output | 1 | Serial line |
| tx_drive | output | 1 | Line driven by the transmitter |
| buf_empty | output | 1 | Holding buffer can accept a character |
| tx_done | output | 1 | Transmit-complete flag |
| empty_irq | output | 1 | Buffer-empty interrupt request |
| done_irq | output | 1 | Transmit-complete interrupt request |

## Verification
The bench collides the tick that ends a frame with three different events. The first is a buffer already holding a character: the next start bit must go out in that same tick and `tx_done` must stay 0. The second is a data write in that exact cycle: `tx_done` must stay 0 and the new character must wait for the following tick. The third is a `done_clr` pulse in that cycle: the new set must win. A further test drops `tx_en` while a frame is still queued, and checks that `tx_drive` holds until the last stop bit has gone out.

// File: rtl/uart_tx_buffered.sv
`timescale 1ns/1ps
module uart_tx_buffered #(
  parameter int MAX_DATA = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       tx_en,
  input  logic [2:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  input  logic       wr_ninth,
  input  logic       ninth_in,
  input  logic       done_clr,
  input  logic       done_ack,
  input  logic       gie,
  input  logic       empty_ie,
  input  logic       done_ie,
  output logic       tx,
  output logic       tx_drive,
  output logic       buf_empty,
  output logic       tx_done,
  output logic       empty_irq,
  output logic       done_irq
);
  localparam int FW = MAX_DATA + 4;
  localparam int CW = $clog2(FW + 1);

  logic [MAX_DATA-1:0] buf_q;
  logic                buf_full, ninth_q, tx_q;
  logic [FW-1:0]       sh, frame;
  logic [CW-1:0]       cnt, flen;
  logic [3:0]          nbits;
  logic                par_bit;

  wire wr_ok = wr_data & tx_en & ~buf_full;
  wire load  = bit_tick & buf_full & (cnt <= CW'(1));

  always_comb begin
    nbits = (char_len >= 3'd4) ? 4'd9 : 4'd5 + {1'b0, char_len};
    par_bit = par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < int'(nbits)) begin
        frame[1+i] = buf_q[i];
        par_bit = par_bit ^ buf_q[i];
      end
    end
    if (par_en) frame[1+int'(nbits)] = par_bit;
    flen = CW'(nbits) + CW'(2) + CW'(par_en) + CW'(two_stop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
      ninth_q  <= 1'b0;
      sh       <= '1;
      cnt      <= '0;
      tx_q     <= 1'b1;
      tx_done  <= 1'b0;
      tx_drive <= 1'b0;
    end else begin
      if (wr_ninth) ninth_q <= ninth_in;
      if (wr_ok) begin
        buf_q    <= {ninth_q, wdata};
        buf_full <= 1'b1;
      end else if (load) begin
        buf_full <= 1'b0;
      end
      if (bit_tick) begin
        if (load) begin
          tx_q <= frame[0];
          sh   <= frame >> 1;
          cnt  <= flen;
        end else if (cnt > CW'(1)) begin
          tx_q <= sh[0];
          sh   <= sh >> 1;
          cnt  <= cnt - CW'(1);
        end else if (cnt == CW'(1)) begin
          tx_q <= 1'b1;
          cnt  <= '0;
        end
      end
      if (bit_tick && cnt == CW'(1) && !buf_full && !wr_ok) tx_done <= 1'b1;
      else if (done_clr || done_ack)                          tx_done <= 1'b0;
      if (tx_en)                          tx_drive <= 1'b1;
      else if (cnt == '0 && !buf_full)    tx_drive <= 1'b0;
    end
  end

  assign tx        = tx_drive ? tx_q : 1'b1;
  assign buf_empty = ~buf_full;
  assign empty_irq = empty_ie & gie & buf_empty;
  assign done_irq  = done_ie & gie & tx_done;
endmodule

module uart_tx_buffered_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_en,
  input logic wr_data,
  input logic tx,
  input logic tx_drive,
  input logic buf_empty,
  input logic tx_done,
  input logic done_irq
);
  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_drive |-> tx);
  // R2
  empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> $past(wr_data && tx_en));
  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(bit_tick) && buf_empty);
  // R11
  drive_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_drive) |-> !$past(tx_en) && $past(buf_empty));
  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drive && $past(tx_drive) && !$past(bit_tick)) |-> $stable(tx));
  // R10
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> tx_done);
endmodule

bind uart_tx_buffered uart_tx_buffered_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
  .wr_data(wr_data), .tx(tx), .tx_drive(tx_drive), .buf_empty(buf_empty),
  .tx_done(tx_done), .done_irq(done_irq)
);

// File: tb/uart_tx_buffered_test.sv
`timescale 1ns/1ps
module uart_tx_buffered_test;
  logic clk = 0, rst_n = 0, bit_tick = 0, tx_en = 0;
  logic [2:0] char_len = 3;
  logic par_en = 0, par_odd = 0, two_stop = 0, wr_data = 0, wr_ninth = 0, ninth_in = 0;
  logic [7:0] wdata = 0;
  logic done_clr = 0, done_ack = 0, gie = 0, empty_ie = 0, done_ie = 0;
  logic tx, tx_drive, buf_empty, tx_done, empty_irq, done_irq;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_tx_buffered uut (.*);

  // vector: [14:12] char_len, [11] par_en, [10] par_odd, [9] two_stop, [8] ninth, [7:0] data
  localparam logic [14:0] VEC [6] = '{
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h13},
    {3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h55},
    {3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 8'h80},
    {3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3F},
    {3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input bit clr = 0, input bit wr = 0, input logic [7:0] d = 0);
    @(negedge clk);
    bit_tick = 1; done_clr = clr; wr_data = wr; wdata = wr ? d : wdata;
    @(negedge clk);
    bit_tick = 0; done_clr = 0; wr_data = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_data = 1; wdata = d;
    @(negedge clk); wr_data = 0;
  endtask

  task automatic pulse_clr;
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0;
  endtask

  function automatic void expect_frame(input logic [14:0] v, output logic [12:0] f, output int len);
    int n, pos, ones;
    logic [8:0] d;
    n = (v[14:12] >= 3'd4) ? 9 : 5 + int'(v[14:12]);
    d = v[8:0];
    f = '1; f[0] = 1'b0; pos = 1; ones = 0;
    for (int i = 0; i < n; i++) begin
      f[pos] = d[i]; pos++;
      if (d[i]) ones++;
    end
    if (v[11]) begin
      f[pos] = v[10] ? ((ones % 2) == 0) : ((ones % 2) == 1);
      pos++;
    end
    pos += v[9] ? 2 : 1;
    len = pos;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [12:0] f, got;
    int len;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(buf_empty == 1 && tx_done == 0 && tx == 1 && tx_drive == 0, "R1", {buf_empty, tx_done, tx, tx_drive}, 4'b1010);
    rst_n = 1;
    @(negedge clk);
    // R2 write ignored while disabled
    write(8'h11);
    chk(buf_empty == 1, "R2 disabled write", buf_empty, 1);
    tick();
    chk(tx == 1, "R2 disabled line", tx, 1);
    tx_en = 1;
    @(negedge clk);
    chk(tx_drive == 1, "R11 drive on", tx_drive, 1);

    foreach (VEC[k]) begin
      char_len = VEC[k][14:12]; par_en = VEC[k][11]; par_odd = VEC[k][10]; two_stop = VEC[k][9];
      @(negedge clk); wr_ninth = 1; ninth_in = VEC[k][8];
      @(negedge clk); wr_ninth = 0; ninth_in = ~VEC[k][8];
      write(VEC[k][7:0]);
      chk(buf_empty == 0, "R2 accepted", buf_empty, 0);
      expect_frame(VEC[k], f, len);
      got = '1;
      for (int b = 0; b < len; b++) begin
        tick();
        got[b] = tx;
        if (b == 0) chk(buf_empty == 1, "R7 moved to shifter", buf_empty, 1);
      end
      // R3 R4 R5 R6 frame contents
      chk(((got ^ f) & ((13'h1 << len) - 13'h1)) == 0, "R3/R4/R5/R6 frame", 32'(got), 32'(f));
      tick();
      chk(tx == 1 && tx_done == 1, "R8 complete", {tx, tx_done}, 2'b11);
      if (k % 2 == 0) begin
        pulse_clr();
        chk(tx_done == 0, "R9 write-one clear", tx_done, 0);
      end else begin
        @(negedge clk); done_ack = 1;
        @(negedge clk); done_ack = 0;
        chk(tx_done == 0, "R9 ack clear", tx_done, 0);
      end
    end

    // R10 interrupt gating
    char_len = 3; par_en = 0; two_stop = 0;
    empty_ie = 1; done_ie = 1; gie = 0;
    @(negedge clk);
    chk(empty_irq == 0, "R10 gie off", empty_irq, 0);
    gie = 1;
    @(negedge clk);
    chk(empty_irq == 1 && done_irq == 0, "R10 empty irq", {empty_irq, done_irq}, 2'b10);

    // R7 back-to-back, no idle bit
    write(8'h0F);
    tick();
    write(8'hF0);
    chk(buf_empty == 0 && empty_irq == 0, "R7 queued", {buf_empty, empty_irq}, 2'b00);
    for (int b = 1; b < 10; b++) tick();
    tick();
    chk(tx == 0 && tx_done == 0 && buf_empty == 1, "R7 back-to-back start", {tx, tx_done, buf_empty}, 3'b001);
    for (int b = 1; b < 10; b++) tick();
    // R8 set wins over clear on the same cycle
    tick(1'b1);
    chk(tx_done == 1 && done_irq == 1, "R8 set beats clear", {tx_done, done_irq}, 2'b11);
    pulse_clr();

    // R8 write in the completion cycle suppresses tx_done
    write(8'h33);
    for (int b = 0; b < 10; b++) tick();
    tick(1'b0, 1'b1, 8'hC3);
    chk(tx_done == 0 && buf_empty == 0 && tx == 1, "R8 write at end", {tx_done, buf_empty, tx}, 3'b001);
    tick();
    chk(tx == 0 && buf_empty == 1, "R7 load after idle", {tx, buf_empty}, 2'b01);
    for (int b = 1; b < 10; b++) tick();
    tick();
    pulse_clr();

    // R11 disable drains queued data first
    write(8'h5A);
    tx_en = 0;
    @(negedge clk);
    chk(tx_drive == 1, "R11 hold while queued", tx_drive, 1);
    for (int b = 0; b < 10; b++) begin
      tick();
      if (b == 0) chk(tx == 0 && tx_drive == 1, "R11 frame still sent", {tx, tx_drive}, 2'b01);
    end
    tick();
    @(negedge clk);
    chk(tx_drive == 0 && tx == 1, "R11 released", {tx_drive, tx}, 2'b01);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule